// File: doc/BRIEF.md
# Machine Trap CSR Register File

This block holds the trap-related control and status registers of a 32-bit hart: the machine and supervisor status, interrupt enable, pending and delegation registers, trap vectors, exception PCs, cause, scratch and trap-value words. It also holds the ISA descriptor, the debug PC, the debug scratch word and the trigger select index. Every software write goes through a per-register legalizer. Each register has its own mask of writable bits, alignment clearing, value fixing and conditions under which the write is dropped. The supervisor status, enable and pending registers are not separate storage. They are masked windows onto the machine registers.

Software accesses use a 12-bit CSR address with the standard numbering, a write data word and a write strobe. The read value is combinational on the address and shows the state before any write in the same cycle. Any address the block does not implement raises an illegal-access flag and reads as zero. The hart's current PC is an input because the ISA descriptor write depends on bit 1 of the PC.

Top module: `mtcsr_file`

## Requirements
- R1: After reset the ISA descriptor (0x301) reads the MAX_ISA parameter (default 0x4014112D), the trigger select reads 0, and every other implemented register reads 0.
- R2: A write to the machine pending register (0x344) changes only bits 1 and 5. All other bits stay 0.
- R3: A write to the machine enable register (0x304) changes only bits 1, 3, 5, 7, 9 and 12. A write to the interrupt delegation register (0x303) changes only bits 1, 5, 9 and 12.
- R4: A write to the exception delegation register (0x302) changes only bits 0, 3, 8, 12, 13 and 15.
- R5: Writes to the machine exception PC (0x341), the supervisor exception PC (0x141) and the debug PC (0x7b1) clear bit 0. A write to the supervisor vector (0x105) clears bits 1:0. A write to the machine vector (0x305) clears only bit 1.
- R6: A write to the ISA descriptor whose bit 2 (compressed) is 0 has no effect at all while bit 1 of `cur_pc` is 1. The same write is accepted while that PC bit is 0, or when bit 2 of the write data is 1.
- R7: An accepted ISA descriptor write changes only bits 12, 0, 5, 3 and 2, and only those of them that are set in MAX_ISA. If bit 5 of the write data is 0, bit 3 is written as 0.
- R8: A machine status write (0x300) changes only bits 1, 3, 5, 7, 8 and 11 through 22. The two-bit field at 12:11 is stored as 0 when the value 2 is written. Bit 31 reads as 1 exactly when bits 14:13 or bits 16:15 are both ones.
- R9: The supervisor status register (0x100) reads the machine status masked to bits 1, 5, 8, 13 to 16, 18 and 19, with the same bit 31. Writing it changes only those bits of the machine status.
- R10: Reading the supervisor enable (0x104) or pending (0x144) register returns the machine register ANDed with the interrupt delegation register. Writing the enable register changes only the delegated bits. Writing the pending register changes only bit 1, and only when bit 1 is delegated.
- R11: A trigger select write (0x7a0) takes effect only when the value is below NUM_TRIG (default 4). Otherwise the old value is kept.
- R12: Any unimplemented address sets `csr_illegal` to 1 and reads 0, and a write to it changes no register.
- R13: The scratch (0x340, 0x140, 0x7b2), cause (0x342, 0x142) and trap value (0x343, 0x143) registers store the full written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_addr | input | 12 | CSR address for both read and write |
| csr_we | input | 1 | Write strobe, one write per cycle it is high |
| csr_wdata | input | XLEN | Write data before legalization |
| cur_pc | input | XLEN | Current PC, bit 1 gates ISA descriptor writes |
| csr_rdata | output | XLEN | Read value of the addressed CSR, 0 when illegal |
| csr_illegal | output | 1 | Addressed CSR is not implemented |

## Verification
The assertions assume that `csr_addr`, `csr_we`, `csr_wdata` and `cur_pc` are held steady across each rising edge. They also assume that no access arrives until the internal reset has been released. The bench drives every access on the falling edge and holds it for exactly one cycle. It waits several cycles after reset before the first access. The bench therefore never changes the PC or the data in the middle of a write. The first access is issued only after the reset synchronizer has released the state.

// File: rtl/mtcsr_pkg.sv
`timescale 1ns/1ps
package mtcsr_pkg;

  // Standard CSR numbers used by the decoder
  localparam logic [11:0] A_SSTATUS   = 12'h100;
  localparam logic [11:0] A_SIE       = 12'h104;
  localparam logic [11:0] A_STVEC     = 12'h105;
  localparam logic [11:0] A_SSCRATCH  = 12'h140;
  localparam logic [11:0] A_SEPC      = 12'h141;
  localparam logic [11:0] A_SCAUSE    = 12'h142;
  localparam logic [11:0] A_STVAL     = 12'h143;
  localparam logic [11:0] A_SIP       = 12'h144;
  localparam logic [11:0] A_MSTATUS   = 12'h300;
  localparam logic [11:0] A_MISA      = 12'h301;
  localparam logic [11:0] A_MEDELEG   = 12'h302;
  localparam logic [11:0] A_MIDELEG   = 12'h303;
  localparam logic [11:0] A_MIE       = 12'h304;
  localparam logic [11:0] A_MTVEC     = 12'h305;
  localparam logic [11:0] A_MSCRATCH  = 12'h340;
  localparam logic [11:0] A_MEPC      = 12'h341;
  localparam logic [11:0] A_MCAUSE    = 12'h342;
  localparam logic [11:0] A_MTVAL     = 12'h343;
  localparam logic [11:0] A_MIP       = 12'h344;
  localparam logic [11:0] A_TSEL      = 12'h7a0;
  localparam logic [11:0] A_DPC       = 12'h7b1;
  localparam logic [11:0] A_DSCRATCH  = 12'h7b2;

  // Writable masks (32-bit view, widened by users)
  localparam logic [31:0] MST_WMASK   = 32'h007F_F9AA; // status writable bits
  localparam logic [31:0] SST_MASK    = 32'h000D_E122; // supervisor status window
  localparam logic [31:0] PEND_WMASK  = 32'h0000_0022; // pending: supervisor sw+timer
  localparam logic [31:0] IRQ_DELEG   = 32'h0000_1222; // delegable interrupts
  localparam logic [31:0] IRQ_ALL     = 32'h0000_12AA; // all enable bits
  localparam logic [31:0] EXC_DELEG   = 32'h0000_B109; // delegable exceptions
  localparam logic [31:0] ISA_MOD     = 32'h0000_102D; // M A F D C
  localparam logic [31:0] SSW_BIT     = 32'h0000_0002; // supervisor software irq

  localparam int PRIV_LO = 11;
  localparam int FS_LO   = 13;
  localparam int XS_LO   = 15;
  localparam int ISA_C   = 2;
  localparam int ISA_D   = 3;
  localparam int ISA_F   = 5;

  // Decoded selects for the registers with special write rules
  typedef struct packed {
    logic mstatus;
    logic sstatus;
    logic misa;
    logic medeleg;
    logic mideleg;
    logic mie;
    logic sie;
    logic mip;
    logic sip;
    logic tsel;
  } csr_sel_t;

  // Plain word registers: table of address and bits cleared on write
  localparam int PLAIN_N = 12;

  function automatic logic [11:0] plain_addr(input int idx);
    case (idx)
      0:  plain_addr = A_MTVEC;
      1:  plain_addr = A_MSCRATCH;
      2:  plain_addr = A_MEPC;
      3:  plain_addr = A_MCAUSE;
      4:  plain_addr = A_MTVAL;
      5:  plain_addr = A_STVEC;
      6:  plain_addr = A_SSCRATCH;
      7:  plain_addr = A_SEPC;
      8:  plain_addr = A_SCAUSE;
      9:  plain_addr = A_STVAL;
      10: plain_addr = A_DPC;
      default: plain_addr = A_DSCRATCH;
    endcase
  endfunction

  function automatic logic [31:0] plain_clr(input int idx);
    case (idx)
      0:        plain_clr = 32'h2;  // machine vector: bit 1 only
      5:        plain_clr = 32'h3;  // supervisor vector: bits 1:0
      2, 7, 10: plain_clr = 32'h1;  // PCs: bit 0
      default:  plain_clr = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/mtcsr_decode.sv
`timescale 1ns/1ps
module mtcsr_decode
  import mtcsr_pkg::*;
(
  input  logic [11:0]        addr,
  output csr_sel_t           sel,
  output logic [PLAIN_N-1:0] plain_sel,
  output logic               hit
);

  always_comb begin
    sel         = '0;
    sel.mstatus = (addr == A_MSTATUS);
    sel.sstatus = (addr == A_SSTATUS);
    sel.misa    = (addr == A_MISA);
    sel.medeleg = (addr == A_MEDELEG);
    sel.mideleg = (addr == A_MIDELEG);
    sel.mie     = (addr == A_MIE);
    sel.sie     = (addr == A_SIE);
    sel.mip     = (addr == A_MIP);
    sel.sip     = (addr == A_SIP);
    sel.tsel    = (addr == A_TSEL);
  end

  for (genvar i = 0; i < PLAIN_N; i++) begin : g_plain
    assign plain_sel[i] = (addr == plain_addr(i));
  end

  assign hit = (|sel) | (|plain_sel);

endmodule

// File: rtl/mtcsr_plain_bank.sv
`timescale 1ns/1ps
module mtcsr_plain_bank
  import mtcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [PLAIN_N-1:0]             wsel,
  input  logic [XLEN-1:0]                wdata,
  output logic [PLAIN_N-1:0][XLEN-1:0]   q
);

  for (genvar i = 0; i < PLAIN_N; i++) begin : g_word
    localparam logic [XLEN-1:0] CLR = XLEN'(plain_clr(i));
    logic            en;
    logic [XLEN-1:0] nxt;
    logic [XLEN-1:0] r;

    always_comb begin
      en  = we & wsel[i];
      nxt = wdata & ~CLR;   // R5 alignment rule per entry
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  r <= '0;
      else if (en) r <= nxt;
    end

    assign q[i] = r;
  end

endmodule

// File: rtl/mtcsr_state.sv
`timescale 1ns/1ps
module mtcsr_state
  import mtcsr_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] MAX_ISA  = 32'h4014_112D,
  parameter int              NUM_TRIG = 4,
  localparam int             TSEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  csr_sel_t          sel,
  input  logic [XLEN-1:0]   wdata,
  input  logic              pc_bit1,
  output logic [XLEN-1:0]   mstatus_rd,
  output logic [XLEN-1:0]   sstatus_rd,
  output logic [XLEN-1:0]   misa_q,
  output logic [TSEL_W-1:0] tsel_q
);

  localparam logic [XLEN-1:0] MWM    = XLEN'(MST_WMASK);
  localparam logic [XLEN-1:0] SWM    = XLEN'(SST_MASK);
  localparam logic [XLEN-1:0] ISA_WM = XLEN'(ISA_MOD) & MAX_ISA;
  localparam logic [XLEN-1:0] SD_BIT = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0]   mstatus_q, mstatus_d, st_src;
  logic              mstatus_en;
  logic              sd;
  logic [XLEN-1:0]   misa_d, isa_val;
  logic              misa_en, isa_drop;
  logic [TSEL_W-1:0] tsel_d;
  logic              tsel_en;

  // Status: the supervisor window is merged first, then the machine mask
  always_comb begin
    st_src     = sel.sstatus ? ((mstatus_q & ~SWM) | (wdata & SWM)) : wdata;
    mstatus_d  = (mstatus_q & ~MWM) | (st_src & MWM);
    if (mstatus_d[PRIV_LO+1:PRIV_LO] == 2'b10)
      mstatus_d[PRIV_LO+1:PRIV_LO] = 2'b00;   // R8 reserved level -> user
    mstatus_en = we & (sel.mstatus | sel.sstatus);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mstatus_q <= '0;
    else if (mstatus_en) mstatus_q <= mstatus_d;
  end

  assign sd         = (&mstatus_q[FS_LO+1:FS_LO]) | (&mstatus_q[XS_LO+1:XS_LO]);
  assign mstatus_rd = mstatus_q | (sd ? SD_BIT : '0);
  assign sstatus_rd = (mstatus_q & SWM) | (sd ? SD_BIT : '0);

  // ISA descriptor: drop on alignment hazard, D follows F
  always_comb begin
    isa_drop = ~wdata[ISA_C] & pc_bit1;       // R6
    isa_val  = wdata;
    if (!wdata[ISA_F]) isa_val[ISA_D] = 1'b0; // R7
    misa_d   = (isa_val & ISA_WM) | (misa_q & ~ISA_WM);
    misa_en  = we & sel.misa & ~isa_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       misa_q <= MAX_ISA;
    else if (misa_en) misa_q <= misa_d;
  end

  // Trigger select: only in-range indexes are kept (R11)
  always_comb begin
    tsel_d  = wdata[TSEL_W-1:0];
    tsel_en = we & sel.tsel & (wdata < XLEN'(NUM_TRIG));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tsel_q <= '0;
    else if (tsel_en) tsel_q <= tsel_d;
  end

endmodule

// File: rtl/mtcsr_intr.sv
`timescale 1ns/1ps
module mtcsr_intr
  import mtcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  csr_sel_t        sel,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] mip_q,
  output logic [XLEN-1:0] mie_q,
  output logic [XLEN-1:0] mideleg_q,
  output logic [XLEN-1:0] medeleg_q
);

  localparam logic [XLEN-1:0] PW  = XLEN'(PEND_WMASK);
  localparam logic [XLEN-1:0] EW  = XLEN'(IRQ_ALL);
  localparam logic [XLEN-1:0] DW  = XLEN'(IRQ_DELEG);
  localparam logic [XLEN-1:0] XW  = XLEN'(EXC_DELEG);
  localparam logic [XLEN-1:0] SSW = XLEN'(SSW_BIT);

  logic [XLEN-1:0] mip_d, mie_d, mideleg_d, medeleg_d;
  logic [XLEN-1:0] pend_src, en_src, sip_mask;
  logic            mip_en, mie_en, mideleg_en, medeleg_en;

  always_comb begin
    // supervisor views fold into the machine word before the machine mask
    sip_mask   = SSW & mideleg_q;
    pend_src   = sel.sip ? ((mip_q & ~sip_mask) | (wdata & sip_mask)) : wdata;
    en_src     = sel.sie ? ((mie_q & ~mideleg_q) | (wdata & mideleg_q)) : wdata;
    mip_d      = (mip_q & ~PW) | (pend_src & PW);
    mie_d      = (mie_q & ~EW) | (en_src & EW);
    mideleg_d  = (mideleg_q & ~DW) | (wdata & DW);
    medeleg_d  = (medeleg_q & ~XW) | (wdata & XW);
    mip_en     = we & (sel.mip | sel.sip);
    mie_en     = we & (sel.mie | sel.sie);
    mideleg_en = we & sel.mideleg;
    medeleg_en = we & sel.medeleg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mip_q     <= '0;
      mie_q     <= '0;
      mideleg_q <= '0;
      medeleg_q <= '0;
    end else begin
      if (mip_en)     mip_q     <= mip_d;
      if (mie_en)     mie_q     <= mie_d;
      if (mideleg_en) mideleg_q <= mideleg_d;
      if (medeleg_en) medeleg_q <= medeleg_d;
    end
  end

endmodule

// File: rtl/mtcsr_file.sv
`timescale 1ns/1ps
module mtcsr_file
  import mtcsr_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] MAX_ISA  = 32'h4014_112D,
  parameter int              NUM_TRIG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [XLEN-1:0] cur_pc,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal
);

  localparam int TSEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  csr_sel_t                       sel;
  logic [PLAIN_N-1:0]             plain_sel;
  logic                           hit;
  logic [PLAIN_N-1:0][XLEN-1:0]   plain_q;
  logic [XLEN-1:0]                mstatus_rd, sstatus_rd, misa_q;
  logic [TSEL_W-1:0]              tsel_q;
  logic [XLEN-1:0]                mip_q, mie_q, mideleg_q, medeleg_q;
  logic                           pc_unused;
  logic [XLEN-1:0]                rd_c;

  assign pc_unused = ^{cur_pc[XLEN-1:2], cur_pc[0]};

  mtcsr_decode u_dec (
    .addr      (csr_addr),
    .sel       (sel),
    .plain_sel (plain_sel),
    .hit       (hit)
  );

  mtcsr_plain_bank #(.XLEN(XLEN)) u_bank (
    .clk   (clk),
    .rst_n (rst_ns),
    .we    (csr_we),
    .wsel  (plain_sel),
    .wdata (csr_wdata),
    .q     (plain_q)
  );

  mtcsr_state #(.XLEN(XLEN), .MAX_ISA(MAX_ISA), .NUM_TRIG(NUM_TRIG)) u_state (
    .clk        (clk),
    .rst_n      (rst_ns),
    .we         (csr_we),
    .sel        (sel),
    .wdata      (csr_wdata),
    .pc_bit1    (cur_pc[1]),
    .mstatus_rd (mstatus_rd),
    .sstatus_rd (sstatus_rd),
    .misa_q     (misa_q),
    .tsel_q     (tsel_q)
  );

  mtcsr_intr #(.XLEN(XLEN)) u_intr (
    .clk       (clk),
    .rst_n     (rst_ns),
    .we        (csr_we),
    .sel       (sel),
    .wdata     (csr_wdata),
    .mip_q     (mip_q),
    .mie_q     (mie_q),
    .mideleg_q (mideleg_q),
    .medeleg_q (medeleg_q)
  );

  // read mux: selects are mutually exclusive, unmatched reads give zero
  always_comb begin
    rd_c = '0;
    for (int i = 0; i < PLAIN_N; i++) begin
      if (plain_sel[i]) rd_c = plain_q[i];
    end
    if (sel.mstatus) rd_c = mstatus_rd;
    if (sel.sstatus) rd_c = sstatus_rd;
    if (sel.misa)    rd_c = misa_q;
    if (sel.medeleg) rd_c = medeleg_q;
    if (sel.mideleg) rd_c = mideleg_q;
    if (sel.mie)     rd_c = mie_q;
    if (sel.sie)     rd_c = mie_q & mideleg_q;
    if (sel.mip)     rd_c = mip_q;
    if (sel.sip)     rd_c = mip_q & mideleg_q;
    if (sel.tsel)    rd_c = XLEN'(tsel_q);
  end

  assign csr_rdata   = rd_c;
  assign csr_illegal = ~hit;

endmodule

// File: rtl/mtcsr_checks.sv
`timescale 1ns/1ps
module mtcsr_checks
  import mtcsr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_TRIG = 4,
  parameter int TSEL_W   = 2
) (
  input logic              clk,
  input logic              rst_ns,
  input logic [11:0]       csr_addr,
  input logic              csr_we,
  input logic [XLEN-1:0]   csr_wdata,
  input logic              pc_b1,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              csr_illegal,
  input logic [XLEN-1:0]   mip_q,
  input logic [XLEN-1:0]   medeleg_q,
  input logic [XLEN-1:0]   mepc_q,
  input logic [XLEN-1:0]   misa_q,
  input logic [TSEL_W-1:0] tsel_q
);

  a_r2_pending_mask: assert property (@(posedge clk) disable iff (!rst_ns)
    (csr_we && csr_addr == A_MIP) |=> (mip_q == ($past(csr_wdata) & XLEN'(PEND_WMASK))));

  a_r4_edeleg_mask: assert property (@(posedge clk) disable iff (!rst_ns)
    (csr_we && csr_addr == A_MEDELEG) |=> (medeleg_q == ($past(csr_wdata) & XLEN'(EXC_DELEG))));

  a_r5_epc_align: assert property (@(posedge clk) disable iff (!rst_ns)
    (csr_we && csr_addr == A_MEPC) |=> (mepc_q == ($past(csr_wdata) & ~XLEN'(1))));

  a_r6_isa_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (csr_we && csr_addr == A_MISA && !csr_wdata[ISA_C] && pc_b1) |=> $stable(misa_q));

  a_r8_sd_read: assert property (@(posedge clk) disable iff (!rst_ns)
    (csr_addr == A_MSTATUS && csr_rdata[FS_LO+1:FS_LO] == 2'b11) |-> csr_rdata[XLEN-1]);

  a_r11_tsel_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (csr_we && csr_addr == A_TSEL && csr_wdata >= XLEN'(NUM_TRIG)) |=> $stable(tsel_q));

  a_r12_illegal_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    csr_illegal |-> (csr_rdata == '0));

endmodule

bind mtcsr_file mtcsr_checks #(
  .XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .TSEL_W(TSEL_W)
) u_checks (
  .clk         (clk),
  .rst_ns      (rst_ns),
  .csr_addr    (csr_addr),
  .csr_we      (csr_we),
  .csr_wdata   (csr_wdata),
  .pc_b1       (cur_pc[1]),
  .csr_rdata   (csr_rdata),
  .csr_illegal (csr_illegal),
  .mip_q       (mip_q),
  .medeleg_q   (medeleg_q),
  .mepc_q      (plain_q[2]),
  .misa_q      (misa_q),
  .tsel_q      (tsel_q)
);

// File: tb/mtcsr_file_bench.sv
`timescale 1ns/1ps
module mtcsr_file_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] pc;
  logic [31:0] rdata;
  logic        illegal;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  mtcsr_file u_mtcsr_file (
    .clk (clk), .rst_n (rst_n), .csr_addr (addr), .csr_we (we),
    .csr_wdata (wdata), .cur_pc (pc), .csr_rdata (rdata), .csr_illegal (illegal)
  );

  // ---------------- behavioural reference ----------------
  localparam logic [31:0] ISA_RST = 32'h4014_112D;
  logic [31:0] m_st, m_isa, m_edl, m_idl, m_ien, m_pnd, m_tsel;
  logic [31:0] m_word [logic [11:0]];

  function automatic void model_reset();
    m_st = 0; m_isa = ISA_RST; m_edl = 0; m_idl = 0; m_ien = 0; m_pnd = 0; m_tsel = 0;
    m_word.delete();
    foreach (m_word[k]) m_word.delete(k);
    m_word[12'h305] = 0; m_word[12'h340] = 0; m_word[12'h341] = 0; m_word[12'h342] = 0;
    m_word[12'h343] = 0; m_word[12'h105] = 0; m_word[12'h140] = 0; m_word[12'h141] = 0;
    m_word[12'h142] = 0; m_word[12'h143] = 0; m_word[12'h7b1] = 0; m_word[12'h7b2] = 0;
  endfunction

  function automatic logic [31:0] sd_of(input logic [31:0] s);
    return ((s[14:13] == 2'b11) || (s[16:15] == 2'b11)) ? 32'h8000_0000 : 32'h0;
  endfunction

  function automatic void model_status_write(input logic [31:0] v);
    m_st = (m_st & ~32'h007F_F9AA) | (v & 32'h007F_F9AA);
    if (m_st[12:11] == 2'b10) m_st[12:11] = 2'b00;
  endfunction

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d, input logic [31:0] p);
    logic [31:0] v, m;
    case (a)
      12'h300: model_status_write(d);
      12'h100: model_status_write((m_st & ~32'h000D_E122) | (d & 32'h000D_E122));
      12'h301: begin
        if (!(d[2] == 1'b0 && p[1] == 1'b1)) begin
          v = d;
          if (!v[5]) v[3] = 1'b0;
          m = 32'h0000_102D & ISA_RST;
          m_isa = (v & m) | (m_isa & ~m);
        end
      end
      12'h302: m_edl = d & 32'h0000_B109;
      12'h303: m_idl = d & 32'h0000_1222;
      12'h304: m_ien = d & 32'h0000_12AA;
      12'h104: m_ien = ((m_ien & ~m_idl) | (d & m_idl)) & 32'h0000_12AA;
      12'h344: m_pnd = d & 32'h0000_0022;
      12'h144: begin
        m = 32'h2 & m_idl;
        m_pnd = (m_pnd & ~m) | (d & m);
      end
      12'h7a0: if (d < 4) m_tsel = d;
      12'h305: m_word[a] = d & ~32'h2;
      12'h105: m_word[a] = d & ~32'h3;
      12'h341, 12'h141, 12'h7b1: m_word[a] = d & ~32'h1;
      default: if (m_word.exists(a)) m_word[a] = d;
    endcase
  endfunction

  function automatic void model_read(input logic [11:0] a, output logic [31:0] r, output logic ill);
    ill = 1'b0;
    case (a)
      12'h300: r = m_st | sd_of(m_st);
      12'h100: r = (m_st & 32'h000D_E122) | sd_of(m_st);
      12'h301: r = m_isa;
      12'h302: r = m_edl;
      12'h303: r = m_idl;
      12'h304: r = m_ien;
      12'h104: r = m_ien & m_idl;
      12'h344: r = m_pnd;
      12'h144: r = m_pnd & m_idl;
      12'h7a0: r = m_tsel;
      default: begin
        if (m_word.exists(a)) r = m_word[a];
        else begin r = 0; ill = 1'b1; end
      end
    endcase
  endfunction

  // one access per clock, compared before the edge that performs the write
  task automatic op(input logic [11:0] a, input logic [31:0] d, input logic w,
                    input logic [31:0] p, input string tag);
    logic [31:0] er;
    logic        ei;
    @(negedge clk);
    addr = a; wdata = d; we = w; pc = p;
    #1;
    model_read(a, er, ei);
    n_cmp++;
    if (rdata !== er || illegal !== ei) begin
      n_bad++;
      $display("FAIL %s addr %h: rdata %h illegal %b, expected %h %b", tag, a, rdata, illegal, er, ei);
    end
    if (w) model_write(a, d, p);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    op(a, 32'h0, 1'b0, 32'h0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    op(a, d, 1'b1, 32'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] impl [22] = '{12'h100, 12'h104, 12'h105, 12'h140, 12'h141, 12'h142,
                               12'h143, 12'h144, 12'h300, 12'h301, 12'h302, 12'h303,
                               12'h304, 12'h305, 12'h340, 12'h341, 12'h342, 12'h343,
                               12'h344, 12'h7a0, 12'h7b1, 12'h7b2};
    rst_n = 1'b0; addr = 0; we = 0; wdata = 0; pc = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values of every implemented register
    foreach (impl[i]) rd(impl[i], "R1");

    // R12: unimplemented addresses, and a write that must not land anywhere
    rd(12'h000, "R12"); rd(12'h306, "R12"); rd(12'hfff, "R12");
    wr(12'h345, 32'hFFFF_FFFF, "R12");
    foreach (impl[i]) rd(impl[i], "R12");

    // R2 / R3 / R4: interrupt and exception masks
    wr(12'h344, 32'hFFFF_FFFF, "R2"); rd(12'h344, "R2");
    wr(12'h344, 32'h0000_0020, "R2"); rd(12'h344, "R2");
    wr(12'h304, 32'hFFFF_FFFF, "R3"); rd(12'h304, "R3");
    wr(12'h303, 32'hFFFF_FFFF, "R3"); rd(12'h303, "R3");
    wr(12'h302, 32'hFFFF_FFFF, "R4"); rd(12'h302, "R4");
    wr(12'h302, 32'h0000_5A5A, "R4"); rd(12'h302, "R4");

    // R5: alignment rules
    wr(12'h305, 32'hFFFF_FFFF, "R5"); rd(12'h305, "R5");
    wr(12'h105, 32'hFFFF_FFFF, "R5"); rd(12'h105, "R5");
    wr(12'h341, 32'h8000_0003, "R5"); rd(12'h341, "R5");
    wr(12'h141, 32'hFFFF_FFFF, "R5"); rd(12'h141, "R5");
    wr(12'h7b1, 32'h1234_5677, "R5"); rd(12'h7b1, "R5");

    // R13: full-width words
    wr(12'h340, 32'hA5A5_5A5A, "R13"); wr(12'h140, 32'h0F0F_F0F0, "R13");
    wr(12'h7b2, 32'hDEAD_BEEF, "R13"); wr(12'h342, 32'h8000_0007, "R13");
    wr(12'h142, 32'h0000_000D, "R13"); wr(12'h343, 32'hFFFF_FFFF, "R13");
    wr(12'h143, 32'h1357_9BDF, "R13");
    rd(12'h340, "R13"); rd(12'h140, "R13"); rd(12'h7b2, "R13"); rd(12'h342, "R13");
    rd(12'h142, "R13"); rd(12'h343, "R13"); rd(12'h143, "R13");

    // R6: write clearing C dropped while PC bit 1 is set
    op(12'h301, 32'h0, 1'b1, 32'h0000_0102, "R6"); rd(12'h301, "R6");
    op(12'h301, 32'h4, 1'b1, 32'h0000_0102, "R6"); rd(12'h301, "R6");
    // R7: modifiable bits and D tied to F
    op(12'h301, 32'h0, 1'b1, 32'h0000_0100, "R7"); rd(12'h301, "R7");
    wr(12'h301, 32'hFFFF_FFFF, "R7"); rd(12'h301, "R7");
    wr(12'h301, 32'h0000_100C, "R7"); rd(12'h301, "R7");
    wr(12'h301, 32'h0000_0028, "R7"); rd(12'h301, "R7");

    // R8: status mask, privilege fix-up, summary bit
    wr(12'h300, 32'hFFFF_FFFF, "R8"); rd(12'h300, "R8");
    wr(12'h300, 32'h0000_1000, "R8"); rd(12'h300, "R8");
    wr(12'h300, 32'h0001_8000, "R8"); rd(12'h300, "R8");
    wr(12'h300, 32'h0000_4000, "R8"); rd(12'h300, "R8");

    // R9: supervisor status window
    wr(12'h300, 32'h0000_1888, "R9");
    wr(12'h100, 32'hFFFF_FFFF, "R9"); rd(12'h300, "R9"); rd(12'h100, "R9");
    wr(12'h100, 32'h0, "R9"); rd(12'h300, "R9"); rd(12'h100, "R9");

    // R10: supervisor enable / pending through delegation
    wr(12'h303, 32'h0000_0002, "R10"); wr(12'h304, 32'h0, "R10");
    wr(12'h104, 32'hFFFF_FFFF, "R10"); rd(12'h304, "R10"); rd(12'h104, "R10");
    wr(12'h344, 32'h0, "R10");
    wr(12'h144, 32'hFFFF_FFFF, "R10"); rd(12'h344, "R10"); rd(12'h144, "R10");
    wr(12'h303, 32'h0, "R10"); wr(12'h344, 32'h0, "R10");
    wr(12'h144, 32'hFFFF_FFFF, "R10"); rd(12'h344, "R10");
    wr(12'h104, 32'hFFFF_FFFF, "R10"); rd(12'h304, "R10"); rd(12'h104, "R10");

    // R11: trigger select range
    wr(12'h7a0, 32'h1, "R11"); rd(12'h7a0, "R11");
    wr(12'h7a0, 32'h4, "R11"); rd(12'h7a0, "R11");
    wr(12'h7a0, 32'h3, "R11"); rd(12'h7a0, "R11");
    wr(12'h7a0, 32'hFFFF_FFFF, "R11"); rd(12'h7a0, "R11");
    rd(12'h7a0, "R11");

    @(negedge clk); we = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule